// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer that carries 18-bit words between two unrelated clock domains and holds up to 256 of them. A producer pushes words with its own clock through a valid/ready write port. A consumer takes them with a second, independent clock through a valid/ready read port. The read port is fall-through: the oldest stored word is always present on the output while the buffer is not empty, so a read strobe only advances to the next word. An output-enable input releases the read data lines to high impedance, and a separate output reports whether the block is driving them.

Beside the data path the block reports its fill level on plain status pins. These are an active-low full pin, an active-low empty pin, a half-full pin and one combined pin that is high near either end of the range. The two offsets that set where that combined pin is high are loaded in-band. While the program-enable input is low, the first one or two accepted writes after reset carry the offsets on the data bus instead of payload.

Back-pressure rules: a word is written at a rising write-clock edge where both `wr_valid` and `wr_ready` are high, and `wr_ready` is low exactly when the buffer is full. A word is consumed at a rising read-clock edge where both `rd_valid` and `rd_ready` are high, and `rd_valid` is high exactly when the read side sees stored data. A producer may hold `wr_valid` high against a low `wr_ready`, and a consumer may hold `rd_ready` high against a low `rd_valid`. Neither changes anything.

Top module: `dcfifo_flags`

## Requirements
- R1: Accepted words leave the read port in the order they were accepted. A word is accepted on a write-clock rising edge with `wr_valid` and `wr_ready` high, and consumed on a read-clock rising edge with `rd_valid` and `rd_ready` high.
- R2: With 256 words held, `full_n` and `wr_ready` are low. A write attempted while full is dropped, and the stored words are left unchanged.
- R3: `empty_n` and `rd_valid` are low when the read side sees no stored word. A read attempted while empty does not move the read position.
- R4: `half_full` is high when the buffer holds 128 or more words and low at 127 or fewer.
- R5: While `prog_en_n` is low, the first accepted write after reset loads the low offset X from `wr_data[7:0]`. The second such write loads the high offset Y from `wr_data[7:0]`. Neither word enters storage.
- R6: `almost_flag` is high when the level is X or less, or 256−Y or more, and low for levels from X+1 to 255−Y.
- R7: If `prog_en_n` is high on the first accepted write after reset, X and Y both become 32 and that write is stored. If only X was loaded when a write arrives with `prog_en_n` high, Y takes the value of X and that write is stored.
- R8: While `rst_n` is low, both positions are cleared, `full_n` is high, `almost_flag` is high, `half_full` is low and `empty_n` is low. The same values hold right after release.
- R9: The first word written into an empty buffer appears on `rd_data`, with `rd_valid` high, without any read strobe.
- R10: When `out_en_n` is high, `q_drive` is low and `rd_data` is released to high impedance. When `out_en_n` is low, `q_drive` is high and `rd_data` carries the head word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, unrelated to wr_clk |
| rst_n | input | 1 | Asynchronous reset of both sides, active low |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | Buffer can take a word (not full) |
| wr_data | input | 18 | Word to write; bits 7:0 carry offsets while programming |
| prog_en_n | input | 1 | Offset programming enable, active low |
| rd_valid | output | 1 | Head word present on rd_data |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_data | output | 18 | Head word, high impedance when released |
| out_en_n | input | 1 | Output enable for rd_data, active low |
| q_drive | output | 1 | High while rd_data is driven |
| full_n | output | 1 | Low when 256 words are held |
| empty_n | output | 1 | Low when no word is visible to the read side |
| half_full | output | 1 | High at 128 or more words |
| almost_flag | output | 1 | High at X or fewer words or at 256−Y or more |

## Verification
A corrupted write position or offset register shows within one write-clock edge, as a wrong `full_n`, `half_full` or `almost_flag` level. That is why the bench compares the flags against its level count after every write while the read side is idle. A read position that slips, or storage overwritten while full, leaves the read side unchanged until the affected word reaches the head. It is exposed at the first read that returns a word out of order, or as a stale word on `rd_data` after the empty-read test. Synchroniser faults only delay `rd_valid`, so it is checked after a settling gap rather than at a fixed edge.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/100ps
package dcfifo_pkg;

  // In-band offset programming progress after reset
  typedef enum logic [1:0] {
    PG_LOW_OFS  = 2'd0,
    PG_HIGH_OFS = 2'd1,
    PG_DONE     = 2'd2
  } prog_state_e;

endpackage

// File: rtl/gray_sync.sv
`timescale 1ns/100ps
module gray_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/fifo_store.sv
`timescale 1ns/100ps
module fifo_store #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // fall-through: head word is read without a clock
  assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_wr_ctrl.sv
`timescale 1ns/100ps
module fifo_wr_ctrl
  import dcfifo_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DEF_OFS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] ofs_in,
  input  logic          prog_en_n,
  input  logic [AW:0]   rgray_s,
  output logic          wr_ready,
  output logic          store_we,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic [AW:0]   level,
  output logic          full_n,
  output logic          half_full,
  output logic          almost_flag
);

  localparam logic [AW:0]   DEPTH_V = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0]   HALF_V  = {2'b01, {(AW-1){1'b0}}};
  localparam logic [AW-1:0] DEF_V   = AW'(DEF_OFS);

  logic [AW:0]   rbin_s;
  logic [AW:0]   wbin_nxt;
  logic [AW-1:0] ofs_lo, ofs_hi;
  prog_state_e   pst;
  logic          fire, prog_hit, at_full;

  always_comb begin
    rbin_s[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  assign level    = wbin - rbin_s;
  assign at_full  = (level == DEPTH_V);
  assign wr_ready = ~at_full;
  assign full_n   = (level < DEPTH_V);

  assign fire     = wr_valid & wr_ready;
  assign prog_hit = fire & ~prog_en_n & (pst != PG_DONE);
  assign store_we = fire & ~prog_hit;
  assign wbin_nxt = wbin + (AW+1)'(store_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      pst    <= PG_LOW_OFS;
      ofs_lo <= DEF_V;
      ofs_hi <= DEF_V;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      if (fire) begin
        case (pst)
          PG_LOW_OFS: begin
            if (!prog_en_n) begin
              ofs_lo <= ofs_in;
              pst    <= PG_HIGH_OFS;
            end else begin
              ofs_lo <= DEF_V;
              ofs_hi <= DEF_V;
              pst    <= PG_DONE;
            end
          end
          PG_HIGH_OFS: begin
            ofs_hi <= prog_en_n ? ofs_lo : ofs_in;
            pst    <= PG_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign half_full   = (level >= HALF_V);
  assign almost_flag = (level <= {1'b0, ofs_lo}) ||
                       (level >= (DEPTH_V - {1'b0, ofs_hi}));

endmodule

// File: rtl/fifo_rd_ctrl.sv
`timescale 1ns/100ps
module fifo_rd_ctrl #(
  parameter int AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_ready,
  input  logic [AW:0] wgray_s,
  output logic        rd_valid,
  output logic [AW:0] rbin,
  output logic [AW:0] rgray
);

  logic [AW:0] rbin_nxt;
  logic        fire;

  assign rd_valid = (rgray != wgray_s);
  assign fire     = rd_ready & rd_valid;
  assign rbin_nxt = rbin + (AW+1)'(fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

endmodule

// File: rtl/dcfifo_flags.sv
`timescale 1ns/100ps
module dcfifo_flags #(
  parameter int DW          = 18,
  parameter int DEPTH       = 256,
  parameter int DEF_OFS     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          prog_en_n,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  input  logic          out_en_n,
  output logic          q_drive,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_full,
  output logic          almost_flag
);

  localparam int AW = $clog2(DEPTH);

  logic [AW:0]   wr_bin, wr_gray, wr_level;
  logic [AW:0]   rd_bin, rd_gray;
  logic [AW:0]   rgray_at_w, wgray_at_r;
  logic          store_we;
  logic [DW-1:0] head_word;

  fifo_wr_ctrl #(.AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
    .clk         (wr_clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .ofs_in      (wr_data[AW-1:0]),
    .prog_en_n   (prog_en_n),
    .rgray_s     (rgray_at_w),
    .wr_ready    (wr_ready),
    .store_we    (store_we),
    .wbin        (wr_bin),
    .wgray       (wr_gray),
    .level       (wr_level),
    .full_n      (full_n),
    .half_full   (half_full),
    .almost_flag (almost_flag)
  );

  gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk   (wr_clk),
    .rst_n (rst_n),
    .din   (rd_gray),
    .dout  (rgray_at_w)
  );

  gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk   (rd_clk),
    .rst_n (rst_n),
    .din   (wr_gray),
    .dout  (wgray_at_r)
  );

  fifo_rd_ctrl #(.AW(AW)) u_rd (
    .clk      (rd_clk),
    .rst_n    (rst_n),
    .rd_ready (rd_ready),
    .wgray_s  (wgray_at_r),
    .rd_valid (rd_valid),
    .rbin     (rd_bin),
    .rgray    (rd_gray)
  );

  fifo_store #(.DW(DW), .AW(AW)) u_mem (
    .clk   (wr_clk),
    .we    (store_we),
    .waddr (wr_bin[AW-1:0]),
    .wdata (wr_data),
    .raddr (rd_bin[AW-1:0]),
    .rdata (head_word)
  );

  assign empty_n = rd_valid;
  assign q_drive = ~out_en_n;
  assign rd_data = q_drive ? head_word : {DW{1'bz}};

endmodule

// File: rtl/dcfifo_flags_chk.sv
`timescale 1ns/100ps
module dcfifo_flags_chk #(
  parameter int DEPTH = 256
) (
  input logic                     wr_clk,
  input logic                     rd_clk,
  input logic                     rst_n,
  input logic                     full_n,
  input logic                     empty_n,
  input logic                     half_full,
  input logic                     almost_flag,
  input logic [$clog2(DEPTH):0]   wr_bin,
  input logic [$clog2(DEPTH):0]   rd_bin,
  input logic [$clog2(DEPTH):0]   level
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  // R8
  always @(posedge wr_clk) begin
    if (!rst_n) begin
      reset_flags_chk: assert (full_n && !half_full && almost_flag && !empty_n)
        else $error("reset flag values wrong");
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    level <= DEPTH_V);

  // R2
  full_hold_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> wr_bin == $past(wr_bin));

  // R3
  empty_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> rd_bin == $past(rd_bin));

  // R4
  full_half_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> half_full);

  // R6
  full_almost_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> almost_flag);

endmodule

bind dcfifo_flags dcfifo_flags_chk #(.DEPTH(DEPTH)) u_flags_chk (
  .wr_clk      (wr_clk),
  .rd_clk      (rd_clk),
  .rst_n       (rst_n),
  .full_n      (full_n),
  .empty_n     (empty_n),
  .half_full   (half_full),
  .almost_flag (almost_flag),
  .wr_bin      (wr_bin),
  .rd_bin      (rd_bin),
  .level       (wr_level)
);

// File: tb/test_dcfifo_flags.sv
`timescale 1ns/100ps
module test_dcfifo_flags;

  logic        wr_clk = 1'b0;
  logic        rd_clk = 1'b0;
  logic        rst_n  = 1'b0;
  logic        wr_valid = 1'b0;
  logic [17:0] wr_data  = '0;
  logic        prog_en_n = 1'b1;
  logic        rd_ready  = 1'b0;
  logic        out_en_n  = 1'b0;
  logic        wr_ready, rd_valid, q_drive;
  logic        full_n, empty_n, half_full, almost_flag;
  logic [17:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  // behavioural reference model
  logic [17:0] mq [$];
  int mx = 32, my = 32, pst = 0;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  dcfifo_flags i_dcfifo_flags (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .prog_en_n(prog_en_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .out_en_n(out_en_n), .q_drive(q_drive),
    .full_n(full_n), .empty_n(empty_n), .half_full(half_full),
    .almost_flag(almost_flag)
  );

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic model_accept(input logic [17:0] d, input logic pen_n);
    if (pst != 2 && !pen_n) begin
      if (pst == 0) begin mx = int'(d[7:0]); pst = 1; end
      else begin my = int'(d[7:0]); pst = 2; end
    end else begin
      if (pst == 0) begin mx = 32; my = 32; end
      else if (pst == 1) my = mx;
      pst = 2;
      mq.push_back(d);
    end
  endtask

  task automatic wflags(input string tag);
    int cnt;
    cnt = mq.size();
    check({tag, " R2 full_n"}, int'(full_n), int'(cnt != 256));
    check({tag, " R2 wr_ready"}, int'(wr_ready), int'(cnt != 256));
    check({tag, " R4 half_full"}, int'(half_full), int'(cnt >= 128));
    check({tag, " R6 almost_flag"}, int'(almost_flag),
          int'((cnt <= mx) || (cnt >= 256 - my)));
  endtask

  task automatic wr_word(input logic [17:0] d, input logic pen_n, input string tag);
    bit ok;
    @(negedge wr_clk);
    wr_valid = 1'b1; wr_data = d; prog_en_n = pen_n;
    ok = wr_ready;
    @(posedge wr_clk);
    if (ok) model_accept(d, pen_n);
    @(negedge wr_clk);
    wr_valid = 1'b0;
    wflags(tag);
  endtask

  task automatic rd_word(input string tag);
    bit ok;
    logic [17:0] d, e;
    @(negedge rd_clk);
    rd_ready = 1'b1;
    ok = rd_valid; d = rd_data;
    check({tag, " R3 rd_valid"}, int'(rd_valid), int'(mq.size() != 0));
    @(posedge rd_clk);
    if (ok && mq.size() != 0) begin
      e = mq.pop_front();
      check({tag, " R1 order"}, int'(d), int'(e));
    end
    @(negedge rd_clk);
    rd_ready = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(negedge wr_clk);
  endtask

  task automatic do_reset(input string tag);
    @(negedge wr_clk);
    rst_n = 1'b0; wr_valid = 1'b0; rd_ready = 1'b0; prog_en_n = 1'b1;
    repeat (3) @(negedge wr_clk);
    check({tag, " R8 full_n in reset"}, int'(full_n), 1);
    check({tag, " R8 empty_n in reset"}, int'(empty_n), 0);
    check({tag, " R8 half_full in reset"}, int'(half_full), 0);
    check({tag, " R8 almost in reset"}, int'(almost_flag), 1);
    rst_n = 1'b1;
    mq.delete(); pst = 0; mx = 32; my = 32;
    repeat (3) @(negedge wr_clk);
    check({tag, " R8 empty_n after"}, int'(empty_n), 0);
    check({tag, " R8 rd_valid after"}, int'(rd_valid), 0);
    wflags({tag, " R8 after"});
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset("first");

    // R5: program X=5, Y=10; neither word is stored
    wr_word(18'h00005, 1'b0, "R5 progX");
    wr_word(18'h0000A, 1'b0, "R5 progY");
    settle();
    check("R5 no store after programming", int'(empty_n), 0);
    prog_en_n = 1'b1;

    // fill to the top, flags compared after every write
    for (int i = 0; i < 256; i++)
      wr_word(18'h10000 + 18'(i * 7), 1'b1, "fill");
    // R2: writes against full are dropped
    for (int i = 0; i < 3; i++)
      wr_word(18'h3ABCD, 1'b1, "R2 overfill");
    settle();

    // R9: head word shown without any read strobe
    check("R9 rd_valid", int'(rd_valid), 1);
    check("R9 head word", int'(rd_data), int'(mq[0]));

    // R10: output enable
    @(negedge rd_clk); out_en_n = 1'b1;
    @(negedge rd_clk);
    check("R10 released q_drive", int'(q_drive), 0);
    out_en_n = 1'b0;
    @(negedge rd_clk);
    check("R10 driven q_drive", int'(q_drive), 1);
    check("R10 driven data", int'(rd_data), int'(mq[0]));

    // drain, comparing each word
    for (int i = 0; i < 256; i++) rd_word("drain");
    settle();
    check("R3 empty_n after drain", int'(empty_n), 0);
    wflags("after drain");

    // R3: reads against empty do not move the read position
    @(negedge rd_clk); rd_ready = 1'b1;
    repeat (6) @(negedge rd_clk);
    rd_ready = 1'b0;
    wr_word(18'h01234, 1'b1, "R3 probe");
    settle();
    check("R3 probe visible", int'(rd_valid), 1);
    check("R3 probe word", int'(rd_data), 18'h01234);
    rd_word("R3 probe read");

    // R7: defaults when first write is a normal one (X=Y=32)
    wr_word(18'h00111, 1'b1, "pre-reset");
    do_reset("R8 nonempty");
    for (int i = 0; i < 224; i++)
      wr_word(18'h20000 + 18'(i), 1'b1, "R7 defaults");
    check("R7 default mx", mx, 32);
    check("R7 first word stored", int'(mq.size()), 224);

    // R7: only X programmed, so Y follows X (=3)
    do_reset("R7 x-only");
    wr_word(18'h00003, 1'b0, "R7 progX");
    for (int i = 0; i < 253; i++)
      wr_word(18'h30000 + 18'(i), 1'b1, "R7 Y=X");
    check("R7 almost at 253", int'(almost_flag), 1);

    // R1: concurrent traffic with stalls on both sides
    do_reset("stream");
    fork
      begin
        int i = 0;
        int c = 0;
        bit ok;
        while (i < 300) begin
          @(negedge wr_clk);
          wr_valid = (c % 4) != 3;
          wr_data = 18'h00800 + 18'(i);
          prog_en_n = 1'b1;
          ok = wr_valid & wr_ready;
          @(posedge wr_clk);
          if (ok) begin model_accept(wr_data, 1'b1); i++; end
          c++;
        end
        @(negedge wr_clk); wr_valid = 1'b0;
      end
      begin
        int got = 0;
        int c = 0;
        bit ok;
        logic [17:0] d, e;
        while (got < 300) begin
          @(negedge rd_clk);
          rd_ready = (c % 5) != 4;
          ok = rd_ready & rd_valid; d = rd_data;
          @(posedge rd_clk);
          if (ok) begin
            if (mq.size() == 0) check("R1 stream pop on empty model", 1, 0);
            else begin e = mq.pop_front(); check("R1 stream order", int'(d), int'(e)); end
            got++;
          end
          c++;
        end
        @(negedge rd_clk); rd_ready = 1'b0;
      end
    join
    settle();
    check("R3 empty after stream", int'(empty_n), 0);
    wflags("after stream");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule